// File: doc/BRIEF.md
# Multi-Mode Integer Divider

This block is the iterative integer divide unit of a processor core. It takes a 32-bit dividend, a divisor, a signed/unsigned flag and a 2-bit operation select. From these it produces one of three result formats. The first is a narrow divide that packs a 16-bit quotient and a 16-bit remainder into one 32-bit word. The second is a full-width divide that returns only the quotient. The third is a full-width divide that returns only the remainder. One restoring shift-subtract datapath computes one quotient bit per clock for every format. A formatting stage then applies sign correction, checks for overflow and packs the result.

The core pulses `start` while the unit is idle. The unit raises `busy` for the whole operation and then pulses `done` for one cycle. At that point `result`, `overflow` and `div_zero` are valid, and they hold until the next operation is accepted. A zero divisor takes a shortcut path and finishes without iterating. A result that cannot be represented raises `overflow` and leaves `result` at its earlier value, so the destination register is untouched.

The controller has four states. IDLE waits for work. CALC runs the iterations. ADJUST corrects signs, packs the result and tests for overflow. FINISH raises `done`. The transitions are as follows:
- accept: IDLE to CALC, on start with a nonzero divisor.
- zero bypass: IDLE to FINISH, on start with a zero divisor.
- last bit: CALC to ADJUST, once the final quotient bit is produced.
- commit: ADJUST to FINISH.
- release: FINISH to IDLE.

Top module: `intdiv_unit`

## Requirements
- R1: After reset `busy`, `done`, `overflow` and `div_zero` are 0 and `result` is 0.
- R2: With `op_sel`=1 the result is the 32-bit quotient. It is unsigned when `is_signed`=0. When `is_signed`=1 it is two's complement and truncated toward zero.
- R3: With `op_sel`=2 the result is the 32-bit remainder. In signed mode the remainder takes the sign of the dividend.
- R4: With `op_sel`=0 only `divisor[15:0]` is used, sign-extended when signed. The result carries the 16-bit remainder in bits 31:16 and the 16-bit quotient in bits 15:0.
- R5: `op_sel`=3 behaves exactly like `op_sel`=1.
- R6: With a nonzero divisor, `done` is high in the 34th cycle counted from the cycle in which `start` is accepted. `busy` is high from the next cycle up to and including the `done` cycle.
- R7: A zero divisor (the low 16 bits in mode 0, all 32 bits otherwise) gives `done` and `div_zero`=1 in the cycle after acceptance. `overflow` is 0 and `result` is unchanged.
- R8: In mode 0 a quotient outside 0..65535 (unsigned) or −32768..32767 (signed) sets `overflow`=1 and leaves `result` unchanged.
- R9: A signed −2^31 / −1 sets `overflow` and leaves `result` unchanged in modes 1 and 3. In mode 2 it returns 0 with no overflow.
- R10: `start` and operand changes while `busy` is high are ignored.
- R11: `done` is high for exactly one cycle. `overflow` and `div_zero` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a divide; accepted when not busy |
| is_signed | input | 1 | 1 = two's complement operands |
| op_sel | input | 2 | 0 packed 16/16, 1 quotient, 2 remainder, 3 quotient |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor (low 16 bits in mode 0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Formatted result, held between operations |
| overflow | output | 1 | Quotient not representable |
| div_zero | output | 1 | Divisor was zero |

## Verification
A normal divide completes 34 cycles after the accepting edge: one load, 32 iteration edges and one commit edge. A zero divisor completes after a single edge. The bench drives inputs on falling edges and counts falling edges from the accepting edge until `done`. It compares that count with 34 or 1, checks the outputs in the `done` cycle, and checks one cycle later that `done` has dropped. For overflow and zero-divide cases the expected result is the value left by the previous operation, which the bench tracks itself.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic [1:0] {
        OP_PACK16   = 2'd0,
        OP_QUOT     = 2'd1,
        OP_REM      = 2'd2,
        OP_QUOT_ALT = 2'd3
    } div_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_ADJUST = 2'd2,
        ST_FINISH = 2'd3
    } div_state_e;

endpackage

// File: rtl/intdiv_operand_prep.sv
module intdiv_operand_prep #(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic         half_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] mag_n,
    output logic [W-1:0] mag_d,
    output logic         neg_quo,
    output logic         neg_rem,
    output logic         zero_div
);
    localparam int H = W / 2;

    logic [W-1:0] dvs_eff;
    logic         n_neg;
    logic         d_neg;

    always_comb begin
        if (half_mode) begin
            dvs_eff = {{H{is_signed & divisor[H-1]}}, divisor[H-1:0]};
        end else begin
            dvs_eff = divisor;
        end
        n_neg    = is_signed & dividend[W-1];
        d_neg    = is_signed & dvs_eff[W-1];
        mag_n    = n_neg ? (~dividend + 1'b1) : dividend;
        mag_d    = d_neg ? (~dvs_eff + 1'b1) : dvs_eff;
        neg_quo  = n_neg ^ d_neg;
        neg_rem  = n_neg;
        zero_div = (dvs_eff == '0);
    end

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_n,
    input  logic [W-1:0] mag_d,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag,
    output logic         last
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  acc_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;
    logic          fits;

    always_comb begin
        shifted = {acc_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
        fits    = ~trial[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            quo_q <= mag_n;
            dvs_q <= mag_d;
            cnt_q <= '0;
        end else if (step) begin
            acc_q <= fits ? trial[W-1:0] : shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign quo_mag = quo_q;
    assign rem_mag = acc_q;
    assign last    = (cnt_q == CW'(W - 1));

endmodule

// File: rtl/intdiv_result_fmt.sv
module intdiv_result_fmt
    import intdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  div_op_e      op,
    input  logic         is_signed,
    input  logic         neg_quo,
    input  logic         neg_rem,
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    output logic [W-1:0] value,
    output logic         ovf
);
    localparam int           H        = W / 2;
    localparam logic [W-1:0] HALF_LIM = W'(1) << (H - 1);

    logic [W-1:0] quo_s;
    logic [W-1:0] rem_s;
    logic         half_ovf;

    always_comb begin
        quo_s = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
        rem_s = neg_rem ? (~rem_mag + 1'b1) : rem_mag;

        if (!is_signed) begin
            half_ovf = |quo_mag[W-1:H];
        end else if (neg_quo) begin
            half_ovf = (quo_mag > HALF_LIM);
        end else begin
            half_ovf = (quo_mag >= HALF_LIM);
        end

        unique case (op)
            OP_PACK16: begin
                value = {rem_s[H-1:0], quo_s[H-1:0]};
                ovf   = half_ovf;
            end
            OP_REM: begin
                value = rem_s;
                ovf   = 1'b0;
            end
            OP_QUOT, OP_QUOT_ALT: begin
                value = quo_s;
                ovf   = is_signed & ~neg_quo & quo_mag[W-1];
            end
            default: begin
                value = quo_s;
                ovf   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_signed,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              overflow,
    output logic              div_zero
);
    div_state_e state_q;
    div_state_e state_d;

    div_op_e           op_q;
    logic              sgn_q;
    logic              negq_q;
    logic              negr_q;

    logic [DATA_W-1:0] mag_n;
    logic [DATA_W-1:0] mag_d;
    logic              neg_quo;
    logic              neg_rem;
    logic              zero_div;
    logic [DATA_W-1:0] quo_mag;
    logic [DATA_W-1:0] rem_mag;
    logic              last;
    logic [DATA_W-1:0] fmt_val;
    logic              fmt_ovf;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start;

    intdiv_operand_prep #(.W(DATA_W)) u_prep (
        .is_signed (is_signed),
        .half_mode (op_sel == 2'd0),
        .dividend  (dividend),
        .divisor   (divisor),
        .mag_n     (mag_n),
        .mag_d     (mag_d),
        .neg_quo   (neg_quo),
        .neg_rem   (neg_rem),
        .zero_div  (zero_div)
    );

    intdiv_core #(.W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state_q == ST_CALC),
        .mag_n   (mag_n),
        .mag_d   (mag_d),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag),
        .last    (last)
    );

    intdiv_result_fmt #(.W(DATA_W)) u_fmt (
        .op        (op_q),
        .is_signed (sgn_q),
        .neg_quo   (negq_q),
        .neg_rem   (negr_q),
        .quo_mag   (quo_mag),
        .rem_mag   (rem_mag),
        .value     (fmt_val),
        .ovf       (fmt_ovf)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = zero_div ? ST_FINISH : ST_CALC;
                end
            end
            ST_CALC: begin
                if (last) begin
                    state_d = ST_ADJUST;
                end
            end
            ST_ADJUST: state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output and operation-context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            overflow <= 1'b0;
            div_zero <= 1'b0;
            op_q     <= OP_PACK16;
            sgn_q    <= 1'b0;
            negq_q   <= 1'b0;
            negr_q   <= 1'b0;
        end else if (accept) begin
            overflow <= 1'b0;
            div_zero <= zero_div;
            op_q     <= div_op_e'(op_sel);
            sgn_q    <= is_signed;
            negq_q   <= neg_quo;
            negr_q   <= neg_rem;
        end else if (state_q == ST_ADJUST) begin
            if (fmt_ovf) begin
                overflow <= 1'b1;
            end else begin
                result <= fmt_val;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FINISH);

endmodule

// File: rtl/intdiv_checker.sv
module intdiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op_sel,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic         overflow,
    input logic         div_zero
);
    localparam int H = W / 2;

    logic zero_req;
    assign zero_req = (op_sel == 2'd0) ? (divisor[H-1:0] == '0) : (divisor == '0);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);  // R1

    AST_DONE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);  // R6

    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && zero_req) |=> (done && div_zero && !overflow));  // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> $stable(result));  // R8

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({overflow, div_zero}));  // R8

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);  // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R11

    AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(overflow) || done));  // R11

endmodule

bind intdiv_unit intdiv_checker #(.W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_sel   (op_sel),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .overflow (overflow),
    .div_zero (div_zero)
);

// File: tb/sim_intdiv_unit.sv
module sim_intdiv_unit;

    typedef struct packed {
        logic [1:0]  op;
        logic        sgn;
        logic [31:0] n;
        logic [31:0] d;
        logic [31:0] exp;
        logic        ovf;
        logic        dz;
    } vec_t;

    localparam int NV = 17;
    // exp is ignored (previous result expected) when ovf or dz is set
    localparam vec_t VEC [NV] = '{
        '{2'd1, 1'b0, 32'd100,       32'd7,          32'h0000000E, 1'b0, 1'b0}, // R2
        '{2'd1, 1'b1, 32'hFFFFFF9C,  32'd7,          32'hFFFFFFF2, 1'b0, 1'b0}, // R2
        '{2'd2, 1'b1, 32'hFFFFFF9C,  32'd7,          32'hFFFFFFFE, 1'b0, 1'b0}, // R3
        '{2'd2, 1'b1, 32'd100,       32'hFFFFFFF9,   32'h00000002, 1'b0, 1'b0}, // R3
        '{2'd2, 1'b0, 32'hFFFFFFFF,  32'h00000010,   32'h0000000F, 1'b0, 1'b0}, // R3
        '{2'd1, 1'b0, 32'hFFFFFFFF,  32'd1,          32'hFFFFFFFF, 1'b0, 1'b0}, // R2
        '{2'd0, 1'b0, 32'd100000,    32'hABCD012C,   32'h0064014D, 1'b0, 1'b0}, // R4
        '{2'd0, 1'b1, 32'hFFFFFC18,  32'd7,          32'hFFFAFF72, 1'b0, 1'b0}, // R4
        '{2'd0, 1'b1, 32'd1000,      32'h0000FFF9,   32'h0006FF72, 1'b0, 1'b0}, // R4
        '{2'd3, 1'b0, 32'd1000,      32'd10,         32'h00000064, 1'b0, 1'b0}, // R5
        '{2'd0, 1'b1, 32'hFFFF0000,  32'd2,          32'h00008000, 1'b0, 1'b0}, // R4 boundary
        '{2'd0, 1'b0, 32'h00010000,  32'd1,          32'h0,        1'b1, 1'b0}, // R8
        '{2'd0, 1'b1, 32'h00010000,  32'd2,          32'h0,        1'b1, 1'b0}, // R8
        '{2'd1, 1'b1, 32'h80000000,  32'hFFFFFFFF,   32'h0,        1'b1, 1'b0}, // R9
        '{2'd2, 1'b1, 32'h80000000,  32'hFFFFFFFF,   32'h00000000, 1'b0, 1'b0}, // R9
        '{2'd1, 1'b0, 32'd5,         32'd0,          32'h0,        1'b0, 1'b1}, // R7
        '{2'd0, 1'b0, 32'd5,         32'h00010000,   32'h0,        1'b0, 1'b1}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic        overflow;
    logic        div_zero;

    int errors = 0;
    int checks = 0;
    logic [31:0] last_res = '0;

    always #10 clk = ~clk;

    intdiv_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .op_sel(op_sel), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .result(result),
        .overflow(overflow), .div_zero(div_zero)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation at a falling edge; returns falling edges until done.
    task automatic run_op(input logic [1:0] op, input logic sgn,
                          input logic [31:0] n, input logic [31:0] d,
                          input bit poke_busy, output int cyc);
        op_sel = op; is_signed = sgn; dividend = n; divisor = d; start = 1'b1;
        cyc = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (i == 1) start = 1'b0;
            if (poke_busy && i == 5) begin
                start = 1'b1; op_sel = 2'd2; divisor = 32'd3; dividend = 32'd1;
            end
            if (poke_busy && i == 8) start = 1'b0;
            if (done) begin
                cyc = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] expv;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 result", result, 32'd0);
        chk("R1 flags", {30'd0, overflow, div_zero}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_op(VEC[k].op, VEC[k].sgn, VEC[k].n, VEC[k].d, 1'b0, cyc);
            expv = (VEC[k].ovf || VEC[k].dz) ? last_res : VEC[k].exp;
            // R6 / R7 latency
            chk(VEC[k].dz ? "R7 latency" : "R6 latency", cyc, VEC[k].dz ? 32'd1 : 32'd34);
            chk("R2-5 result (R8 R9 hold)", result, expv);
            chk("R8 R9 overflow flag", {31'd0, overflow}, {31'd0, VEC[k].ovf});
            chk("R7 div_zero flag", {31'd0, div_zero}, {31'd0, VEC[k].dz});
            chk("R6 busy at done", {31'd0, busy}, 32'd1);
            last_res = result;
            @(negedge clk);
            chk("R11 done single cycle", {31'd0, done}, 32'd0);
            chk("R11 flags held", {30'd0, overflow, div_zero}, {30'd0, VEC[k].ovf, VEC[k].dz});
        end

        // R10: start and operand changes during busy are ignored
        run_op(2'd1, 1'b0, 32'd1000, 32'd10, 1'b1, cyc);
        chk("R10 latency unaffected", cyc, 32'd34);
        chk("R10 result from first op", result, 32'd100);
        @(negedge clk);
        chk("R10 no second op busy", {31'd0, busy}, 32'd0);
        chk("R10 no second done", {31'd0, done}, 32'd0);
        last_res = result;

        // R6 busy raised in cycle after accept
        op_sel = 2'd2; is_signed = 1'b0; dividend = 32'd17; divisor = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy after accept", {31'd0, busy}, 32'd1);
        repeat (33) @(negedge clk);
        chk("R6 done at 34", {31'd0, done}, 32'd1);
        chk("R3 remainder 17%5", result, 32'd2);
        @(negedge clk);

        // R8 unsigned half-mode upper limit
        run_op(2'd0, 1'b0, 32'h0000FFFF, 32'd1, 1'b0, cyc);
        chk("R8 max fitting quotient", result, 32'h0000FFFF);
        chk("R8 no overflow at limit", {31'd0, overflow}, 32'd0);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule